// File: doc/BRIEF.md
# SPI Transfer Chunk Sequencer

This block is the control sequencer in front of an SPI shift engine. A transaction is requested with two separate lengths: how many words are to be sent and how many words are to be captured. The sequencer splits that transaction into chunks and runs them back to back. Chip select stays asserted for the whole transaction.

Before each chunk the sequencer looks at the two remaining counts. It picks the chunk length and decides whether transmit data, receive capture or both are enabled. It then pulses a start to the engine and waits for the engine's done pulse. When the two lengths differ, the first chunk is full duplex and only as long as the shorter side. Neither side ever needs a buffer longer than the one it was given. The chunk after that covers the rest of the longer side on its own. When both remaining counts are zero, the sequencer drops chip select, pulses a completion flag and returns to idle.

States: IDLE (waits for a request), SELECT (asserts chip select for one cycle), ISSUE (selection step: starts a chunk, or finishes when nothing remains), WAIT_DONE (holds until the engine reports done), FINISH (releases chip select and flags completion). Transitions: IDLE→SELECT on a request; SELECT→ISSUE always; ISSUE→WAIT_DONE when work remains; ISSUE→FINISH when both counts are zero; WAIT_DONE→ISSUE on done; FINISH→IDLE always. A synchronous reset forces IDLE.

Top module: `spi_chunk_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `sel_active`, `busy`, `eng_start` and `xfer_done` are all low.
- R2: A request seen in IDLE captures both lengths, and `sel_active` and `busy` are high in the next cycle.
- R3: When the selection step finds both remaining counts zero (including a request with both lengths zero), `xfer_done` is high for exactly one cycle. In that cycle `sel_active` is low, and the block is idle in the following cycle.
- R4: With the remaining transmit count zero and the receive count nonzero, a chunk starts with `eng_tx_en`=0, `eng_rx_en`=1 and `eng_len` equal to the remaining receive count.
- R5: With the remaining receive count zero and the transmit count nonzero, a chunk starts with `eng_tx_en`=1, `eng_rx_en`=0 and `eng_len` equal to the remaining transmit count.
- R6: With both remaining counts nonzero, a chunk starts with `eng_tx_en`=1, `eng_rx_en`=1 and `eng_len` equal to the smaller of the two.
- R7: `eng_start` is a one-cycle pulse, one per chunk. `sel_active` stays high from the SELECT cycle through every chunk and every gap between chunks.
- R8: On each done pulse, both remaining counts drop by the chunk length and saturate at zero. The selection step then repeats, so a transaction with both lengths nonzero and unequal runs exactly two chunks.
- R9: A request raised while the block is busy is ignored. The running chunk sequence is unchanged, and no new transaction starts after completion.
- R10: `busy` is high from the first chip select cycle through the FINISH cycle, and low in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transaction request, sampled in IDLE only |
| req_tx_len | input | CNT_W | Words to transmit |
| req_rx_len | input | CNT_W | Words to receive |
| eng_done | input | 1 | Engine finished the current chunk |
| sel_active | output | 1 | Chip select, active high |
| busy | output | 1 | Transaction in progress |
| eng_start | output | 1 | One-cycle chunk start pulse |
| eng_len | output | CNT_W | Chunk length in words, valid with `eng_start` |
| eng_tx_en | output | 1 | Chunk drives transmit data |
| eng_rx_en | output | 1 | Chunk captures received data |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench sweeps every pair of transmit and receive lengths from 0 to 6. For each pair it computes the expected chunk list arithmetically and checks every chunk's length and enables, the number of start pulses, and chip select in each gap.

Several corner cases are covered:
- A design that picked the longer side for a duplex chunk would show a wrong `eng_len`.
- A design that did not saturate the decrement would wrap a count and issue a spurious extra chunk.
- Zero-length transactions check that completion happens without any start.
- Requests raised mid-transaction check that a busy block neither reloads its counts nor starts a second transaction.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_ISSUE,
        ST_WAIT_DONE,
        ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        CH_NONE,
        CH_RX_ONLY,
        CH_TX_ONLY,
        CH_DUPLEX
    } chunk_kind_e;

endpackage

// File: rtl/spi_rem_ctr.sv
module spi_rem_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    input  logic [W-1:0] dec_amt,
    output logic [W-1:0] value
);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= (value > dec_amt) ? (value - dec_amt) : '0;
        end
    end

    // R8
    no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> value <= $past(value));

endmodule

// File: rtl/spi_chunk_pick.sv
module spi_chunk_pick
    import spi_chunk_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] tx_rem,
    input  logic [W-1:0] rx_rem,
    output chunk_kind_e  kind,
    output logic [W-1:0] len
);

    logic tx_zero;
    logic rx_zero;

    assign tx_zero = (tx_rem == '0);
    assign rx_zero = (rx_rem == '0);

    always_comb begin
        unique case ({tx_zero, rx_zero})
            2'b11: begin
                kind = CH_NONE;
                len  = '0;
            end
            2'b10: begin
                kind = CH_RX_ONLY;
                len  = rx_rem;
            end
            2'b01: begin
                kind = CH_TX_ONLY;
                len  = tx_rem;
            end
            default: begin
                kind = CH_DUPLEX;
                len  = (tx_rem < rx_rem) ? tx_rem : rx_rem;
            end
        endcase
    end

endmodule

// File: rtl/spi_chunk_seq.sv
module spi_chunk_seq
    import spi_chunk_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [CNT_W-1:0] req_tx_len,
    input  logic [CNT_W-1:0] req_rx_len,
    input  logic             eng_done,
    output logic             sel_active,
    output logic             busy,
    output logic             eng_start,
    output logic [CNT_W-1:0] eng_len,
    output logic             eng_tx_en,
    output logic             eng_rx_en,
    output logic             xfer_done
);

    seq_state_e       state_q;
    seq_state_e       state_d;
    chunk_kind_e      pick_kind;
    logic [CNT_W-1:0] pick_len;
    logic [CNT_W-1:0] chunk_len_q;
    logic [CNT_W-1:0] tx_rem;
    logic [CNT_W-1:0] rx_rem;
    logic             cap_req;
    logic             chunk_fin;

    assign cap_req   = (state_q == ST_IDLE) && req_valid;
    assign chunk_fin = (state_q == ST_WAIT_DONE) && eng_done;

    spi_rem_ctr #(.W(CNT_W)) tx_ctr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cap_req),
        .load_val (req_tx_len),
        .dec      (chunk_fin),
        .dec_amt  (chunk_len_q),
        .value    (tx_rem)
    );

    spi_rem_ctr #(.W(CNT_W)) rx_ctr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (cap_req),
        .load_val (req_rx_len),
        .dec      (chunk_fin),
        .dec_amt  (chunk_len_q),
        .value    (rx_rem)
    );

    spi_chunk_pick #(.W(CNT_W)) pick_i (
        .tx_rem (tx_rem),
        .rx_rem (rx_rem),
        .kind   (pick_kind),
        .len    (pick_len)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_SELECT;
            ST_SELECT:    state_d = ST_ISSUE;
            ST_ISSUE:     state_d = (pick_kind == CH_NONE) ? ST_FINISH : ST_WAIT_DONE;
            ST_WAIT_DONE: if (eng_done) state_d = ST_ISSUE;
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            chunk_len_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_ISSUE) chunk_len_q <= pick_len;
        end
    end

    always_comb begin
        sel_active = 1'b0;
        busy       = 1'b0;
        eng_start  = 1'b0;
        xfer_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SELECT: begin
                sel_active = 1'b1;
                busy       = 1'b1;
            end
            ST_ISSUE: begin
                sel_active = 1'b1;
                busy       = 1'b1;
                eng_start  = (pick_kind != CH_NONE);
            end
            ST_WAIT_DONE: begin
                sel_active = 1'b1;
                busy       = 1'b1;
            end
            ST_FINISH: begin
                busy      = 1'b1;
                xfer_done = 1'b1;
            end
            default: ;
        endcase
    end

    assign eng_len   = pick_len;
    assign eng_tx_en = (pick_kind == CH_TX_ONLY) || (pick_kind == CH_DUPLEX);
    assign eng_rx_en = (pick_kind == CH_RX_ONLY) || (pick_kind == CH_DUPLEX);

    // R7
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R6
    duplex_min_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_start && eng_tx_en && eng_rx_en) |-> (eng_len <= tx_rem && eng_len <= rx_rem));

    // R3
    done_empty_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |-> (tx_rem == '0 && rx_rem == '0));

    // R3
    cs_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sel_active) |-> xfer_done);

    // R4
    nonzero_len_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> eng_len != '0);

endmodule

// File: tb/spi_chunk_seq_tb_top.sv
module spi_chunk_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int MAX_LEN    = 6;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic [CNT_W-1:0] req_tx_len = '0;
    logic [CNT_W-1:0] req_rx_len = '0;
    logic             eng_done = 1'b0;
    logic             sel_active;
    logic             busy;
    logic             eng_start;
    logic [CNT_W-1:0] eng_len;
    logic             eng_tx_en;
    logic             eng_rx_en;
    logic             xfer_done;

    int checks   = 0;
    int failures = 0;
    int start_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_chunk_seq #(.CNT_W(CNT_W)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_tx_len (req_tx_len),
        .req_rx_len (req_rx_len),
        .eng_done   (eng_done),
        .sel_active (sel_active),
        .busy       (busy),
        .eng_start  (eng_start),
        .eng_len    (eng_len),
        .eng_tx_en  (eng_tx_en),
        .eng_rx_en  (eng_rx_en),
        .xfer_done  (xfer_done)
    );

    always @(posedge clk) if (!rst && eng_start) start_cnt <= start_cnt + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_txn(input int t, input int r, input bit poke);
        int mt = t;
        int mr = r;
        int nchunk = 0;
        int s0 = start_cnt;
        @(negedge clk);
        req_valid  = 1'b1;
        req_tx_len = CNT_W'(t);
        req_rx_len = CNT_W'(r);
        @(negedge clk);
        req_valid = 1'b0;
        chk(sel_active == 1'b1, "R2", "cs after request", int'(sel_active), 1);
        chk(busy == 1'b1, "R10", "busy at select", int'(busy), 1);
        while (mt != 0 || mr != 0) begin
            int el;
            int etx;
            int erx;
            string tag;
            if (mt == 0) begin el = mr; etx = 0; erx = 1; tag = "R4"; end
            else if (mr == 0) begin el = mt; etx = 1; erx = 0; tag = "R5"; end
            else begin el = (mt < mr) ? mt : mr; etx = 1; erx = 1; tag = "R6"; end
            for (int k = 0; k < 8 && !eng_start; k++) @(negedge clk);
            chk(eng_start == 1'b1, tag, "start seen", int'(eng_start), 1);
            chk(int'(eng_len) == el, tag, "chunk len", int'(eng_len), el);
            chk(int'(eng_tx_en) == etx, tag, "tx enable", int'(eng_tx_en), etx);
            chk(int'(eng_rx_en) == erx, tag, "rx enable", int'(eng_rx_en), erx);
            chk(sel_active == 1'b1, "R7", "cs at start", int'(sel_active), 1);
            if (poke) begin
                req_valid  = 1'b1;
                req_tx_len = CNT_W'(7);
                req_rx_len = CNT_W'(3);
            end
            @(negedge clk);
            chk(eng_start == 1'b0, "R7", "start pulse width", int'(eng_start), 0);
            @(negedge clk);
            chk(sel_active == 1'b1, "R7", "cs in chunk", int'(sel_active), 1);
            req_valid = 1'b0;
            eng_done  = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            mt = (mt > el) ? mt - el : 0;
            mr = (mr > el) ? mr - el : 0;
            nchunk++;
            if (mt != 0 || mr != 0)
                chk(sel_active == 1'b1, "R7", "cs between chunks", int'(sel_active), 1);
        end
        for (int k = 0; k < 8 && !xfer_done; k++) @(negedge clk);
        chk(xfer_done == 1'b1, "R3", "completion", int'(xfer_done), 1);
        chk(sel_active == 1'b0, "R3", "cs at completion", int'(sel_active), 0);
        chk(busy == 1'b1, "R10", "busy at finish", int'(busy), 1);
        chk(start_cnt - s0 == nchunk, "R8", "chunk count", start_cnt - s0, nchunk);
        @(negedge clk);
        chk(xfer_done == 1'b0, "R3", "completion width", int'(xfer_done), 0);
        chk(busy == 1'b0, "R10", "idle after finish", int'(busy), 0);
        if (poke) begin
            @(negedge clk);
            chk(sel_active == 1'b0 && busy == 1'b0, "R9", "no relaunch",
                int'(sel_active), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sel_active && !busy && !eng_start && !xfer_done, "R1", "in reset",
            int'({sel_active, busy, eng_start, xfer_done}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!sel_active && !busy && !eng_start && !xfer_done, "R1", "after reset",
            int'({sel_active, busy, eng_start, xfer_done}), 0);
        for (int t = 0; t <= MAX_LEN; t++) begin
            for (int r = 0; r <= MAX_LEN; r++) begin
                run_txn(t, r, 1'b0);
            end
        end
        // R9: requests raised during busy chunks
        run_txn(2, 5, 1'b1);
        run_txn(4, 1, 1'b1);
        run_txn(3, 3, 1'b1);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule